// File: doc/BRIEF.md
# Output Driver Protection Controller

This block supervises twelve output switches, arranged as six low-side/high-side pairs, and produces the final enable for each switch. Its inputs are comparator flags from the analog front end:
- supply overvoltage and undervoltage;
- overcurrent and open load for each output;
- overtemperature warning and overtemperature shutdown.

It also takes the hardware inhibit pin and the fields of the control word: the switch commands, the open-load detection enable, the delay select, the software run bit and a status-reset pulse. Millisecond delays are counted in ticks from a parameterized prescaler. The default settings give a 0.5 ms tick at 50 MHz.

Supply faults and short circuits must persist for a programmable number of ticks before the outputs shut down. The supply-fail, short-circuit and overtemperature-shutdown indications are sticky, and only a status-reset pulse clears them. The outputs themselves recover as soon as the supply is back to normal. Each output's status bit means "switch is on" while that switch is commanded on. While the switch is commanded off, the same bit means "open load seen".

Top module: `drv_protect`

## Requirements
- R1: While `ov_i` is held high, all outputs go to 0 and `psf_o` sets once the overvoltage delay has elapsed. The delay is OV_SHORT_T ticks (default 7) when `dly_sel_i` is 0 and OV_LONG_T ticks (default 30) when it is 1.
- R2: While `uv_i` is held high, all outputs go to 0 and `psf_o` sets after a fixed UV_T ticks (default 20), whatever the value of `dly_sel_i`.
- R3: When a fault flag drops before its delay has elapsed, its timer restarts from zero, and no shutdown or sticky bit results.
- R4: The outputs follow their commands again in the same cycle the supply flags return low. `psf_o` stays 1 until a status-reset pulse arrives.
- R5: When `oc_i[k]` is high while output k is enabled, output k is switched off after SC_SHORT_T ticks (default 25, `dly_sel_i`=0) or SC_LONG_T ticks (default 200, `dly_sel_i`=1), and `scd_o` sets. `scd_o` stays 1 until a status-reset pulse arrives.
- R6: An output switched off for a short circuit stays off until either `srr_i` pulses or its command bit is cleared.
- R7: A one-cycle pulse on `srr_i` clears `psf_o`, `scd_o` and the overtemperature-shutdown latch in the following cycle, provided no fault sets them again in that cycle.
- R8: `inh_o` is 1 when `inh_pin_i` is 0 or `run_i` is 0. While `inh_o` is 1, every output enable is 0.
- R9: For an output commanded on, `stat_o[k]` equals `out_en_o[k]`.
- R10: For an output commanded off, `stat_o[k]` equals `ol_i[k]` when `ol_det_n_i` is 0 and is 0 when `ol_det_n_i` is 1. `ol_i[k]` has no effect on the status of an output that is commanded on.
- R11: `tp_o` is high while `ot_warn_i` is high. A high `ot_shut_i` latches a shutdown from the next cycle onward: all outputs go to 0, all `stat_o` bits read 1 and `tp_o` reads 1, and this lasts until a status-reset pulse.
- R12: With no fault active and no standby, `out_en_o` equals `sw_en_i`. Bit 2k controls low-side switch k+1 and bit 2k+1 controls high-side switch k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ov_i | input | 1 | Supply overvoltage flag |
| uv_i | input | 1 | Supply undervoltage flag |
| oc_i | input | N_OUT | Per-output overcurrent flags |
| ol_i | input | N_OUT | Per-output open-load flags |
| ot_warn_i | input | 1 | Overtemperature warning |
| ot_shut_i | input | 1 | Overtemperature shutdown request |
| inh_pin_i | input | 1 | Inhibit pin, low = standby |
| run_i | input | 1 | Software run bit, low = standby |
| sw_en_i | input | N_OUT | Switch commands |
| ol_det_n_i | input | 1 | Open-load detection enable, active low |
| dly_sel_i | input | 1 | Long/short delay select |
| srr_i | input | 1 | Status-reset pulse |
| out_en_o | output | N_OUT | Final output enables |
| stat_o | output | N_OUT | Per-output status bits |
| psf_o | output | 1 | Sticky supply-fail bit |
| scd_o | output | 1 | Sticky short-circuit bit |
| inh_o | output | 1 | Standby indication |
| tp_o | output | 1 | Temperature prewarning or shutdown |

## Verification
The enables, the status bits, `inh_o` and the warning part of `tp_o` are combinational from the inputs and the latched state, so they are due in the same cycle as a stimulus. The sticky bits, the short-circuit trips and the overtemperature latch change one clock edge after their cause. A delayed shutdown lands on the edge at which the tick count reaches its limit, so its exact cycle depends on the prescaler phase since reset. The bench's behavioural model tracks that phase and compares every output one time unit after the inputs change in each cycle. The directed checks sample a few cycles before and after each delay limit, so they do not depend on the tick phase.

// File: rtl/drv_protect_pkg.sv
package drv_protect_pkg;
  typedef enum logic {DLY_SHORT = 1'b0, DLY_LONG = 1'b1} dly_sel_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/fault_timer.sv
module fault_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cond_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // restart on every gap in the condition; saturate at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!cond_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = cond_i && (cnt_q >= limit_i);
endmodule

// File: rtl/drv_protect.sv
module drv_protect
  import drv_protect_pkg::*;
#(
  parameter int unsigned N_OUT      = 12,
  parameter int unsigned TICK_DIV   = 25000,
  parameter int unsigned OV_SHORT_T = 7,
  parameter int unsigned OV_LONG_T  = 30,
  parameter int unsigned UV_T       = 20,
  parameter int unsigned SC_SHORT_T = 25,
  parameter int unsigned SC_LONG_T  = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ov_i,
  input  logic             uv_i,
  input  logic [N_OUT-1:0] oc_i,
  input  logic [N_OUT-1:0] ol_i,
  input  logic             ot_warn_i,
  input  logic             ot_shut_i,
  input  logic             inh_pin_i,
  input  logic             run_i,
  input  logic [N_OUT-1:0] sw_en_i,
  input  logic             ol_det_n_i,
  input  logic             dly_sel_i,
  input  logic             srr_i,
  output logic [N_OUT-1:0] out_en_o,
  output logic [N_OUT-1:0] stat_o,
  output logic             psf_o,
  output logic             scd_o,
  output logic             inh_o,
  output logic             tp_o
);
  localparam int unsigned MAX_T = max_of(max_of(max_of(OV_SHORT_T, OV_LONG_T), UV_T),
                                         max_of(SC_SHORT_T, SC_LONG_T));
  localparam int unsigned TW = $clog2(MAX_T + 1);

  dly_sel_e dly;
  logic [TW-1:0] ov_lim, uv_lim, sc_lim;
  logic tick, ov_done, uv_done, supply_off, standby, global_off;
  logic psf_q, scd_q, ots_q;
  logic [N_OUT-1:0] trip_q, sc_done, en;

  assign dly    = dly_sel_e'(dly_sel_i);
  assign ov_lim = (dly == DLY_LONG) ? TW'(OV_LONG_T) : TW'(OV_SHORT_T);
  assign sc_lim = (dly == DLY_LONG) ? TW'(SC_LONG_T) : TW'(SC_SHORT_T);
  assign uv_lim = TW'(UV_T);

  tick_gen #(.DIV(TICK_DIV)) u_tick (.clk_i, .rst_ni, .tick_o(tick));

  fault_timer #(.W(TW)) u_ov_tmr (
    .clk_i, .rst_ni, .cond_i(ov_i), .tick_i(tick), .limit_i(ov_lim), .done_o(ov_done)
  );
  fault_timer #(.W(TW)) u_uv_tmr (
    .clk_i, .rst_ni, .cond_i(uv_i), .tick_i(tick), .limit_i(uv_lim), .done_o(uv_done)
  );

  assign supply_off = ov_done | uv_done;
  assign standby    = ~inh_pin_i | ~run_i;
  assign global_off = standby | supply_off | ots_q;
  assign en         = sw_en_i & ~trip_q & ~{N_OUT{global_off}};

  for (genvar k = 0; k < N_OUT; k++) begin : g_sc
    fault_timer #(.W(TW)) u_sc_tmr (
      .clk_i, .rst_ni, .cond_i(oc_i[k] & en[k]), .tick_i(tick),
      .limit_i(sc_lim), .done_o(sc_done[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      trip_q[k] <= 1'b0;
      else if (sc_done[k])              trip_q[k] <= 1'b1;
      else if (srr_i || !sw_en_i[k])    trip_q[k] <= 1'b0;
    end
  end

  // a set in the same cycle as a status reset takes priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psf_q <= 1'b0;
      scd_q <= 1'b0;
      ots_q <= 1'b0;
    end else begin
      if (supply_off)    psf_q <= 1'b1;
      else if (srr_i)    psf_q <= 1'b0;
      if (|sc_done)      scd_q <= 1'b1;
      else if (srr_i)    scd_q <= 1'b0;
      if (ot_shut_i)     ots_q <= 1'b1;
      else if (srr_i)    ots_q <= 1'b0;
    end
  end

  assign out_en_o = en;
  assign stat_o   = ots_q ? '1 : (en | (~sw_en_i & ol_i & {N_OUT{~ol_det_n_i}}));
  assign psf_o    = psf_q;
  assign scd_o    = scd_q;
  assign inh_o    = standby;
  assign tp_o     = ot_warn_i | ots_q;
endmodule

// File: rtl/drv_protect_chk.sv
module drv_protect_chk #(
  parameter int unsigned N_OUT = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ov_i,
  input logic             uv_i,
  input logic             ot_shut_i,
  input logic [N_OUT-1:0] sw_en_i,
  input logic             srr_i,
  input logic [N_OUT-1:0] out_en_o,
  input logic [N_OUT-1:0] stat_o,
  input logic             psf_o,
  input logic             scd_o,
  input logic             inh_o,
  input logic             tp_o
);
  p_standby_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_o |-> (out_en_o == '0));

  p_psf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psf_o && !srr_i) |=> psf_o);

  p_scd_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scd_o && !srr_i) |=> scd_o);

  p_srr_clears_psf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srr_i && !ov_i && !uv_i) |=> !psf_o);

  p_stat_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o & ~stat_o) == '0);

  p_no_uncommanded_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o & ~sw_en_i) == '0);

  p_ot_shutdown_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_shut_i |=> (out_en_o == '0 && stat_o == '1 && tp_o));
endmodule

bind drv_protect drv_protect_chk #(.N_OUT(N_OUT)) u_chk (.*);

// File: tb/drv_protect_tb.sv
module drv_protect_tb;
  localparam int N = 12;
  localparam int DIV = 2;
  localparam int OVS = 7, OVL = 30, UVT = 20, SCS = 25, SCL = 200;

  logic clk = 0, rst_n = 0;
  logic ov = 0, uv = 0, ot_warn = 0, ot_shut = 0, pin = 1, run = 1;
  logic ol_det_n = 1, dly = 0, srr = 0;
  logic [N-1:0] oc = '0, ol = '0, sw = '0;
  logic [N-1:0] out_en, stat;
  logic psf, scd, inh, tp;

  int nchk = 0, nfail = 0;

  // reference state
  int phase = 0, ov_c = 0, uv_c = 0;
  int sc_c[N];
  bit m_trip[N];
  bit m_psf = 0, m_scd = 0, m_ots = 0;

  always #10 clk = ~clk;

  drv_protect #(.N_OUT(N), .TICK_DIV(DIV), .OV_SHORT_T(OVS), .OV_LONG_T(OVL),
                .UV_T(UVT), .SC_SHORT_T(SCS), .SC_LONG_T(SCL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ov_i(ov), .uv_i(uv), .oc_i(oc), .ol_i(ol),
    .ot_warn_i(ot_warn), .ot_shut_i(ot_shut), .inh_pin_i(pin), .run_i(run),
    .sw_en_i(sw), .ol_det_n_i(ol_det_n), .dly_sel_i(dly), .srr_i(srr),
    .out_en_o(out_en), .stat_o(stat), .psf_o(psf), .scd_o(scd), .inh_o(inh), .tp_o(tp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: compare model and DUT, then advance model across the edge
  task automatic cyc();
    bit tick, sup_off, stby, goff;
    int lim_ov, lim_sc;
    logic [N-1:0] e_en, e_stat;
    bit nx_trip[N];
    int nx_sc[N];
    bit any_sc;
    #1;
    tick = (phase == DIV - 1);
    lim_ov = dly ? OVL : OVS;
    lim_sc = dly ? SCL : SCS;
    sup_off = (ov && ov_c >= lim_ov) || (uv && uv_c >= UVT);
    stby = !pin || !run;
    goff = stby || sup_off || m_ots;
    any_sc = 0;
    for (int k = 0; k < N; k++) e_en[k] = sw[k] && !m_trip[k] && !goff;
    for (int k = 0; k < N; k++) begin
      if (m_ots) e_stat[k] = 1;
      else if (sw[k]) e_stat[k] = e_en[k];
      else e_stat[k] = !ol_det_n && ol[k];
    end
    chk("R12 out_en", 32'(out_en), 32'(e_en));
    chk("R9/R10 stat", 32'(stat), 32'(e_stat));
    chk("R4 psf", 32'(psf), 32'(m_psf));
    chk("R5 scd", 32'(scd), 32'(m_scd));
    chk("R8 inh", 32'(inh), 32'(stby));
    chk("R11 tp", 32'(tp), 32'(ot_warn || m_ots));
    for (int k = 0; k < N; k++) begin
      bit c;
      c = oc[k] && e_en[k];
      nx_trip[k] = m_trip[k];
      if (c && sc_c[k] >= lim_sc) begin nx_trip[k] = 1; any_sc = 1; end
      else if (srr || !sw[k]) nx_trip[k] = 0;
      nx_sc[k] = !c ? 0 : ((tick && sc_c[k] < lim_sc) ? sc_c[k] + 1 : sc_c[k]);
    end
    @(posedge clk);
    for (int k = 0; k < N; k++) begin m_trip[k] = nx_trip[k]; sc_c[k] = nx_sc[k]; end
    if (sup_off) m_psf = 1; else if (srr) m_psf = 0;
    if (any_sc) m_scd = 1; else if (srr) m_scd = 0;
    if (ot_shut) m_ots = 1; else if (srr) m_ots = 0;
    ov_c = !ov ? 0 : ((tick && ov_c < lim_ov) ? ov_c + 1 : ov_c);
    uv_c = !uv ? 0 : ((tick && uv_c < UVT) ? uv_c + 1 : uv_c);
    phase = (phase + 1) % DIV;
    @(negedge clk);
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_srr();
    srr = 1; cyc(); srr = 0; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin sc_c[k] = 0; m_trip[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R12 reset out_en", 32'(out_en), 0);
    chk("R4 reset psf", 32'(psf), 0);
    rst_n = 1;
    cyc();

    // R12 / R9: plain command pass-through
    sw = 12'hA5A; cyc();
    chk("R12 enables follow command", 32'(out_en), 32'h A5A);
    chk("R9 status of on outputs", 32'(stat), 32'h A5A);

    // R10: open-load report only for off outputs
    ol = '1; ol_det_n = 0; cyc();
    chk("R10 open load on off outputs", 32'(stat), 32'h FFF);
    ol_det_n = 1; cyc();
    chk("R10 detection disabled", 32'(stat), 32'h A5A);
    ol = '0; cyc();

    // R8: both standby sources
    pin = 0; cyc();
    chk("R8 pin standby", 32'({inh, out_en}), 32'h1000);
    pin = 1; run = 0; cyc();
    chk("R8 software standby", 32'({inh, out_en}), 32'h1000);
    run = 1; cyc();

    // R3: short overvoltage glitch
    dly = 0; ov = 1; run_n(10); ov = 0; cyc();
    chk("R3 glitch no psf", 32'(psf), 0);
    chk("R3 glitch outputs kept", 32'(out_en), 32'h A5A);
    // R1 short delay
    ov = 1; run_n(12);
    chk("R1 before short ov delay", 32'(out_en), 32'h A5A);
    run_n(6);
    chk("R1 after short ov delay", 32'({psf, out_en}), 32'h1000);
    ov = 0; cyc();
    chk("R4 immediate recovery", 32'(out_en), 32'h A5A);
    chk("R4 psf sticky", 32'(psf), 1);
    run_n(5);
    chk("R4 psf still sticky", 32'(psf), 1);
    pulse_srr();
    chk("R7 srr clears psf", 32'(psf), 0);

    // R1 long delay
    dly = 1; ov = 1; run_n(56);
    chk("R1 before long ov delay", 32'({psf, out_en}), 32'h A5A);
    run_n(8);
    chk("R1 after long ov delay", 32'({psf, out_en}), 32'h1000);
    ov = 0; cyc(); pulse_srr();

    // R2: undervoltage fixed delay, both selects
    dly = 1; uv = 1; run_n(36);
    chk("R2 before uv delay", 32'(psf), 0);
    run_n(8);
    chk("R2 after uv delay", 32'({psf, out_en}), 32'h1000);
    uv = 0; cyc(); pulse_srr();
    dly = 0; uv = 1; run_n(36);
    chk("R2 uv delay ignores select", 32'(psf), 0);
    uv = 0; cyc();

    // R5 short-circuit trip, short delay
    dly = 0; oc[1] = 1; run_n(46);
    chk("R5 before sc delay", 32'(out_en), 32'h A5A);
    run_n(8);
    chk("R5 after sc delay", 32'({scd, out_en}), 32'h1A58);
    oc[1] = 0; run_n(5);
    chk("R6 tripped output stays off", 32'(out_en), 32'h A58);
    pulse_srr();
    chk("R7 srr restores and clears scd", 32'({scd, out_en}), 32'h A5A);
    // R6: command clear releases trip
    oc[1] = 1; run_n(56); oc[1] = 0;
    chk("R5 second trip", 32'(out_en), 32'h A58);
    sw[1] = 0; cyc(); sw[1] = 1; cyc();
    chk("R6 recommand after clear", 32'(out_en), 32'h A5A);
    chk("R5 scd sticky over recommand", 32'(scd), 1);
    pulse_srr();
    // R5 long delay
    dly = 1; oc[3] = 1; run_n(390);
    chk("R5 before long sc delay", 32'(out_en), 32'h A5A);
    run_n(16);
    chk("R5 after long sc delay", 32'(out_en), 32'h A52);
    oc[3] = 0; pulse_srr();

    // R11: temperature
    ot_warn = 1; cyc();
    chk("R11 warning", 32'({tp, out_en}), 32'h1A5A);
    ot_warn = 0; ot_shut = 1; cyc(); ot_shut = 0; run_n(3);
    chk("R11 shutdown latched", 32'({tp, stat, out_en}), 32'h1FFF000);
    pulse_srr();
    chk("R7 srr clears ot shutdown", 32'({tp, out_en}), 32'h0A5A);

    run_n(4);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule